// File: doc/BRIEF.md
# Completion Ring Producer

This block owns the producing end of one circular completion ring kept in host memory. Finished commands arrive as completion requests. Each carries a command tag, a 15-bit status code, the id of the submission queue it came from and that queue's current head. The block buffers the requests in a small FIFO. It writes each one as a ring entry through a simple valid/ready write-request port, and it keeps the ring's tail index and phase tag.

The host consumes entries and reports its new consumer index through a head doorbell. A phase tag travels in bit 0 of every status word and inverts each time the tail wraps. This lets the host tell fresh entries from stale ones without reading a counter. When the ring is full, posting stops and requests wait in the FIFO. A doorbell that frees space lets posting resume on its own. An interrupt pulse is raised after posts and after head updates that leave unread entries, but only when interrupts are enabled for the queue.

Top module: `cq_post_engine`

## Requirements
- R1: After reset, and in the cycle after a `cq_init` pulse, head and tail are 0 and the phase tag is 1. After reset `wr_valid` and `irq_pulse` are low and `req_ready` is high.
- R2: Each accepted write advances the tail by one. When the tail would reach `cfg_size` it returns to 0 and the phase tag inverts.
- R3: The ring is full when (tail+1) mod `cfg_size` equals head. While full, `wr_valid` stays low and pending requests remain queued.
- R4: `wr_status` equals the request's status code in bits 15:1, with the current phase tag in bit 0.
- R5: `wr_addr` equals `cfg_base` + tail × 2^`cfg_entry_exp`, using the tail before it advances.
- R6: A doorbell whose `db_head` is greater than or equal to `cfg_size` leaves the head unchanged and raises no interrupt.
- R7: `irq_pulse` is high for one cycle after each accepted write when `cfg_irq_en` is 1. It is never raised in the cycle after `cfg_irq_en` was 0.
- R8: An accepted doorbell raises `irq_pulse` in the next cycle when the new head differs from the tail, and does not raise it when they are equal.
- R9: Requests are posted in arrival order. A head update that makes room in a full ring lets the oldest pending request post without any further request.
- R10: While `wr_valid` is high and `wr_ready` is low, the request stays presented with an unchanged address, and no entry is consumed.
- R11: `wr_cid`, `wr_sqid` and `wr_sqhd` carry the request's tag, submission queue id and submission queue head unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | Ring base address |
| cfg_size | input | QIDX_W | Number of ring slots (2 or more) |
| cfg_entry_exp | input | EXP_W | log2 of entry size in bytes |
| cfg_irq_en | input | 1 | Interrupt enable for this queue |
| cq_init | input | 1 | Queue creation pulse, resets ring pointers |
| req_valid | input | 1 | Completion request valid |
| req_ready | output | 1 | FIFO can accept a request |
| req_cid | input | 16 | Command tag |
| req_code | input | 15 | Status code |
| req_sqid | input | 16 | Submission queue id |
| req_sqhd | input | 16 | Submission queue head |
| db_valid | input | 1 | Head doorbell write |
| db_head | input | QIDX_W | New consumer head |
| wr_valid | output | 1 | Entry write request |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | ADDR_W | Entry address |
| wr_cid | output | 16 | Entry command tag |
| wr_status | output | 16 | Status code with phase tag in bit 0 |
| wr_sqid | output | 16 | Entry submission queue id |
| wr_sqhd | output | 16 | Entry submission queue head |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The assertions check, on every cycle, the following rules: the tail and phase step and wrap rule, that the tail stays frozen while the ring is full and no doorbell arrives, that out-of-range doorbells leave the head alone, that a stalled write holds its slot, and that a disabled queue never interrupts. The bench scenarios are what show the absolute values of the posted entries: their addresses, the phase tag seen in the status word across a wrap, and the restart of a queued entry after the host frees space. They also show the exact interrupt count for posts and for doorbells that do or do not leave unread entries.

// File: rtl/cq_post_pkg.sv
package cq_post_pkg;
  localparam int CID_W  = 16;
  localparam int CODE_W = 15;
  localparam int SQID_W = 16;
  localparam int SQHD_W = 16;
  localparam int STS_W  = CODE_W + 1;

  typedef struct packed {
    logic [CID_W-1:0]  cid;
    logic [CODE_W-1:0] code;
    logic [SQID_W-1:0] sqid;
    logic [SQHD_W-1:0] sqhd;
  } cpl_req_t;
endpackage

// File: rtl/cq_req_fifo.sv
module cq_req_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign dout  = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q + CW'(push) - CW'(pop);
    if (push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
    if (pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  // R9: ordering store must never overrun or underrun
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/cq_ring_ptr.sv
module cq_ring_ptr #(
  parameter int QIDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [QIDX_W-1:0] size,
  input  logic              adv,
  input  logic              db_valid,
  input  logic [QIDX_W-1:0] db_head,
  output logic [QIDX_W-1:0] tail,
  output logic [QIDX_W-1:0] tail_nxt,
  output logic              phase,
  output logic              full,
  output logic              db_ok
);
  logic [QIDX_W-1:0] head_q, head_d, tail_d, tail_inc;
  logic              phase_d, wrap;

  always_comb begin
    wrap     = (tail == size - QIDX_W'(1));
    tail_inc = wrap ? '0 : tail + QIDX_W'(1);
    full     = (tail_inc == head_q);
    db_ok    = db_valid && (db_head < size);
    tail_d   = tail;
    phase_d  = phase;
    head_d   = head_q;
    if (init) begin
      tail_d  = '0;
      head_d  = '0;
      phase_d = 1'b1;
    end else begin
      if (adv) begin
        tail_d = tail_inc;
        if (wrap) phase_d = ~phase;
      end
      if (db_ok) head_d = db_head;
    end
  end

  assign tail_nxt = tail_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail   <= '0;
      head_q <= '0;
      phase  <= 1'b1;
    end else begin
      tail   <= tail_d;
      head_q <= head_d;
      phase  <= phase_d;
    end
  end

  // R2: step and wrap rule
  a_r2_wrap_flips_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !init && tail == size - QIDX_W'(1)) |=> (tail == '0 && phase != $past(phase)));
  a_r2_step_keeps_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !init && tail != size - QIDX_W'(1)) |=> (tail == $past(tail) + QIDX_W'(1) && $stable(phase)));
  // R3: no tail motion while full
  a_r3_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !init) |=> $stable(tail));
  // R6: out-of-range head ignored
  a_r6_bad_head_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (db_valid && db_head >= size && !init) |=> $stable(head_q));
  // R1: creation resets pointers
  a_r1_init_state: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (tail == '0 && head_q == '0 && phase));
endmodule

// File: rtl/cq_post_engine.sv
module cq_post_engine
  import cq_post_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int QIDX_W     = 8,
  parameter int EXP_W      = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [QIDX_W-1:0] cfg_size,
  input  logic [EXP_W-1:0]  cfg_entry_exp,
  input  logic              cfg_irq_en,
  input  logic              cq_init,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CID_W-1:0]  req_cid,
  input  logic [CODE_W-1:0] req_code,
  input  logic [SQID_W-1:0] req_sqid,
  input  logic [SQHD_W-1:0] req_sqhd,
  input  logic              db_valid,
  input  logic [QIDX_W-1:0] db_head,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [CID_W-1:0]  wr_cid,
  output logic [STS_W-1:0]  wr_status,
  output logic [SQID_W-1:0] wr_sqid,
  output logic [SQHD_W-1:0] wr_sqhd,
  output logic              irq_pulse
);
  localparam int RW = $bits(cpl_req_t);

  cpl_req_t          in_req, head_req;
  logic [RW-1:0]     head_bits;
  logic              f_empty, f_full, push, fire;
  logic [QIDX_W-1:0] tail, tail_nxt;
  logic              phase, ring_full, db_ok, irq_d;

  assign in_req    = '{cid: req_cid, code: req_code, sqid: req_sqid, sqhd: req_sqhd};
  assign req_ready = !f_full;
  assign push      = req_valid && req_ready;
  assign head_req  = cpl_req_t'(head_bits);

  cq_req_fifo #(.W(RW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(in_req),
    .pop(fire), .dout(head_bits), .empty(f_empty), .full(f_full)
  );

  cq_ring_ptr #(.QIDX_W(QIDX_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .init(cq_init), .size(cfg_size),
    .adv(fire), .db_valid(db_valid), .db_head(db_head),
    .tail(tail), .tail_nxt(tail_nxt), .phase(phase),
    .full(ring_full), .db_ok(db_ok)
  );

  always_comb begin
    wr_valid  = !f_empty && !ring_full;
    fire      = wr_valid && wr_ready;
    wr_addr   = cfg_base + (ADDR_W'(tail) << cfg_entry_exp);
    wr_cid    = head_req.cid;
    wr_status = {head_req.code, phase};
    wr_sqid   = head_req.sqid;
    wr_sqhd   = head_req.sqhd;
    irq_d     = cfg_irq_en && (fire || (db_ok && db_head != tail_nxt));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pulse <= 1'b0;
    else        irq_pulse <= irq_d;
  end

  // R10: stalled write keeps its slot
  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !cq_init && !db_valid) |=> (wr_valid && $stable(tail)));
  // R7: disabled queue never interrupts
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en |=> !irq_pulse);
  // R7: a post with interrupts on always pulses
  a_r7_irq_after_post: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cfg_irq_en) |=> irq_pulse);
endmodule

// File: tb/cq_post_engine_tb.sv
module cq_post_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_base;
  logic [7:0]  cfg_size;
  logic [3:0]  cfg_entry_exp;
  logic        cfg_irq_en, cq_init, req_valid, req_ready;
  logic [15:0] req_cid, req_sqid, req_sqhd;
  logic [14:0] req_code;
  logic        db_valid;
  logic [7:0]  db_head;
  logic        wr_valid, wr_ready;
  logic [31:0] wr_addr;
  logic [15:0] wr_cid, wr_status, wr_sqid, wr_sqhd;
  logic        irq_pulse;

  int checks = 0, fails = 0, irq_cnt = 0, cap_n = 0, i0;
  logic [31:0] cap_addr [16];
  logic [15:0] cap_sts [16], cap_cid [16], cap_sqid [16], cap_sqhd [16];
  bit done = 0;

  always #2 clk = ~clk;

  cq_post_engine u_dut (.*);

  // vectors: {cid, code, sqid, sqhd}
  localparam logic [62:0] TBL [3] = '{
    {16'h0011, 15'h0000, 16'h0003, 16'h0005},
    {16'h0022, 15'h0281, 16'h0007, 16'h000a},
    {16'h0033, 15'h7fff, 16'h0001, 16'hffff}
  };

  always @(negedge clk) begin
    if (rst_n && irq_pulse) irq_cnt++;
    if (rst_n && wr_valid && wr_ready && cap_n < 16) begin
      cap_addr[cap_n] = wr_addr; cap_sts[cap_n] = wr_status;
      cap_cid[cap_n] = wr_cid; cap_sqid[cap_n] = wr_sqid; cap_sqhd[cap_n] = wr_sqhd;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [15:0] cid, input logic [14:0] code,
                      input logic [15:0] sqid, input logic [15:0] sqhd);
    req_valid = 1; req_cid = cid; req_code = code; req_sqid = sqid; req_sqhd = sqhd;
    tick(1);
    req_valid = 0;
  endtask

  task automatic ring_db(input logic [7:0] h);
    db_valid = 1; db_head = h;
    tick(1);
    db_valid = 0;
  endtask

  task automatic chk_entry(input int k, input logic [31:0] addr, input logic [14:0] code,
                           input bit ph, input string tag);
    chk(cap_n > k, {tag, " entry present"}, cap_n, k + 1);
    chk(cap_addr[k] == addr, {tag, " R5 address"}, cap_addr[k], addr);
    chk(cap_sts[k] == {code, ph}, {tag, " R4 status/phase"}, cap_sts[k], {code, ph});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_base = 32'h1000; cfg_size = 8'd4; cfg_entry_exp = 4'd4;
    cfg_irq_en = 1; cq_init = 0; req_valid = 0; req_cid = 0; req_code = 0;
    req_sqid = 0; req_sqhd = 0; db_valid = 0; db_head = 0; wr_ready = 1;
    tick(3);
    rst_n = 1;
    tick(1);
    @(negedge clk);
    chk(wr_valid == 0, "R1 wr_valid after reset", wr_valid, 0);
    chk(irq_pulse == 0, "R1 irq after reset", irq_pulse, 0);
    chk(req_ready == 1, "R1 req_ready after reset", req_ready, 1);
    tick(1);

    // table of vectors: three posts from tail 0, phase 1
    for (int i = 0; i < 3; i++)
      push(TBL[i][62:47], TBL[i][46:32], TBL[i][31:16], TBL[i][15:0]);
    tick(4);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk_entry(i, 32'h1000 + 32'(i) * 16, TBL[i][46:32], 1'b1, "R2 R1 table");
      chk(cap_cid[i] == TBL[i][62:47], "R11 cid", cap_cid[i], TBL[i][62:47]);
      chk(cap_sqid[i] == TBL[i][31:16], "R11 sqid", cap_sqid[i], TBL[i][31:16]);
      chk(cap_sqhd[i] == TBL[i][15:0], "R11 sqhd", cap_sqhd[i], TBL[i][15:0]);
    end
    chk(irq_cnt == 3, "R7 one irq per post", irq_cnt, 3);
    tick(1);

    // ring full (tail 3, head 0): fourth request waits
    push(16'h0044, 15'h007f, 16'h0002, 16'h0009);
    tick(5);
    @(negedge clk);
    chk(wr_valid == 0, "R3 no write while full", wr_valid, 0);
    chk(cap_n == 3, "R3 nothing posted while full", cap_n, 3);
    tick(1);

    // out-of-range head ignored
    i0 = irq_cnt;
    ring_db(8'd4);
    tick(3);
    @(negedge clk);
    chk(cap_n == 3, "R6 bad head leaves ring full", cap_n, 3);
    chk(irq_cnt == i0, "R6 bad head no irq", irq_cnt, i0);
    tick(1);

    // head = 2 frees the ring, pending entry posts at slot 3 then wraps
    i0 = irq_cnt;
    ring_db(8'd2);
    tick(3);
    @(negedge clk);
    chk_entry(3, 32'h1030, 15'h007f, 1'b1, "R9 restart after head update");
    chk(cap_cid[3] == 16'h0044, "R9 pending entry order", cap_cid[3], 16'h0044);
    chk(irq_cnt == i0 + 2, "R8 doorbell irq plus post irq", irq_cnt, i0 + 2);
    tick(1);

    // after wrap, phase tag is 0
    push(16'h0055, 15'h0012, 16'h0004, 16'h0001);
    tick(4);
    @(negedge clk);
    chk_entry(4, 32'h1000, 15'h0012, 1'b0, "R2 wrap inverts phase");
    tick(1);

    // head = 1 equals tail 1: no irq
    i0 = irq_cnt;
    ring_db(8'd1);
    tick(2);
    @(negedge clk);
    chk(irq_cnt == i0, "R8 head equals tail no irq", irq_cnt, i0);
    tick(1);

    // backpressure
    wr_ready = 0;
    push(16'h0066, 15'h0100, 16'h0005, 16'h0002);
    tick(3);
    @(negedge clk);
    chk(wr_valid == 1, "R10 request held", wr_valid, 1);
    chk(wr_addr == 32'h1010, "R10 address held", wr_addr, 32'h1010);
    chk(cap_n == 5, "R10 nothing consumed", cap_n, 5);
    tick(1);
    wr_ready = 1;
    tick(2);
    @(negedge clk);
    chk_entry(5, 32'h1010, 15'h0100, 1'b0, "R10 released");
    tick(1);

    // interrupts disabled
    cfg_irq_en = 0;
    i0 = irq_cnt;
    push(16'h0077, 15'h0003, 16'h0006, 16'h0003);
    tick(3);
    @(negedge clk);
    chk_entry(6, 32'h1020, 15'h0003, 1'b0, "R7 post without irq");
    chk(irq_cnt == i0, "R7 no irq when disabled", irq_cnt, i0);
    tick(1);

    // queue re-creation
    cq_init = 1;
    tick(1);
    cq_init = 0;
    cfg_irq_en = 1;
    push(16'h0088, 15'h0040, 16'h0008, 16'h0004);
    tick(3);
    @(negedge clk);
    chk_entry(7, 32'h1000, 15'h0040, 1'b1, "R1 init resets tail and phase");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule